// File: doc/BRIEF.md
# Bundle Instruction-Group Splitter

This block sits between instruction fetch and the issue stage of a wide in-order machine whose compiler marks parallelism explicitly. It receives one 128-bit instruction bundle per accepted handshake and cuts it into a 5-bit template and three 41-bit operation slots. The template carries stop markers. A stop ends an instruction group, and a group is a run of operations that the compiler has promised are free of register dependences between them. Groups do not follow bundle edges. A group ends only at a stop, so it may run across any number of bundles.

The slots wait in a small ordered queue. Each cycle the oldest complete group is presented on a lane vector up to the issue width, with a valid bit for each lane and an end-of-group flag. If a group grows to the issue width before a stop arrives, the first issue-width operations go out with end-of-group low and the rest follow later. The issue stage is assumed to take every presented lane. The input stalls only while the buffered slots cannot leave.

Top module: `vliw_group_splitter`

## Requirements
- R1: The template sits in bundle bits 4:0. Slot 0 is bits 45:5, slot 1 is bits 86:46 and slot 2 is bits 127:87. Operations leave in stream order, with the oldest on lane 0 (bits 40:0 of `out_op`), and none is dropped, repeated or reordered.
- R2: When template bit 0 is 1 there is a stop after slot 2. The group that contains slot 2 leaves with `out_eog` high and with slot 2 on its last valid lane.
- R3: When template bit 1 is 1 there is a stop after slot 1. The group ends at slot 1 with `out_eog` high, and slot 2 opens a new group that leaves in a later cycle.
- R4: Operations that have no stop between them form one group even when they come from different bundles. They are presented together once the closing stop has been accepted.
- R5: A group that reaches ISSUE_W (6) operations with no stop among them is presented as its first six operations with `out_eog` low. If the sixth operation is itself followed by a stop, the six are presented with `out_eog` high.
- R6: The set bits of `out_valid` are always contiguous from lane 0. `out_eog` is high only when at least one lane is valid.
- R7: `in_ready` is high exactly when the buffered slot count, less the lanes presented in the current cycle, is at most 5. The queue holds ISSUE_W+2 slots. When `in_ready` is low, at least one lane is presented in that cycle.
- R8: Each valid lane carries, on `out_tmpl` (5 bits per lane, lane 0 at bits 4:0), the full unmodified template of the bundle that the operation came from.
- R9: Synchronous active-high reset empties the queue. In the cycle after reset, `out_valid` is 0, `out_eog` is 0 and `in_ready` is 1. Slots buffered before the reset never appear.
- R10: Only one group is presented per cycle: the oldest complete one. A younger complete group waits for the next cycle.
- R11: A group completed by a bundle accepted on a clock edge is presented in the cycle that follows that edge, if no older group is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A bundle is offered |
| in_bundle | input | 128 | Offered bundle: template and three slots |
| in_ready | output | 1 | The offered bundle is taken on this edge |
| out_valid | output | ISSUE_W | Lane valid bits, contiguous from lane 0 |
| out_op | output | ISSUE_W*41 | Lane operations, lane 0 in the low bits |
| out_tmpl | output | ISSUE_W*5 | Template of the source bundle for each lane |
| out_eog | output | 1 | The presented operations close their group |

## Verification
Two functions can meet on the same lane set. One is the split at six operations and the other is a stop. When the sixth buffered operation carries a stop, both fire together. The bench provokes this with a stop-free bundle followed by a bundle that stops after slot 2, and it expects six lanes with `out_eog` high, not a split. Ingest and presentation also overlap: with bundles that stop after both slot 1 and slot 2, fed back to back, one group leaves while a new bundle is taken. The queue then fills until `in_ready` falls. The bench judges this by counting stalls, checking every operation's serial number and template, and confirming that the whole stream drains.

// File: rtl/vliw_grp_pkg.sv
package vliw_grp_pkg;

    localparam int BUNDLE_W    = 128;
    localparam int TMPL_W      = 5;
    localparam int SLOT_W      = 41;
    localparam int NSLOT       = 3;
    localparam int STOP_S1_BIT = 1;   // stop after slot 1
    localparam int STOP_S2_BIT = 0;   // stop after slot 2

    typedef struct packed {
        logic [SLOT_W-1:0] op;
        logic [TMPL_W-1:0] tmpl;
        logic              stop;   // a stop follows this slot
    } slot_ent_t;

    function automatic int slot_lsb(input int k);
        return TMPL_W + k * SLOT_W;
    endfunction

    function automatic logic stop_after(input logic [TMPL_W-1:0] t, input int k);
        case (k)
            1:       return t[STOP_S1_BIT];
            2:       return t[STOP_S2_BIT];
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/vliw_grp_unpack.sv
module vliw_grp_unpack
    import vliw_grp_pkg::*;
(
    input  logic [BUNDLE_W-1:0]   bundle,
    output slot_ent_t [NSLOT-1:0] ents
);

    logic [TMPL_W-1:0] tmpl;
    assign tmpl = bundle[TMPL_W-1:0];

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        assign ents[k] = '{op:   bundle[slot_lsb(k) +: SLOT_W],
                           tmpl: tmpl,
                           stop: stop_after(tmpl, k)};
    end

endmodule

// File: rtl/vliw_grp_queue.sv
module vliw_grp_queue
    import vliw_grp_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int HEAD_N = 6,
    parameter int CNT_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   push,
    input  slot_ent_t [NSLOT-1:0]  ents_in,
    input  logic [CNT_W-1:0]       pop_n,
    output slot_ent_t [HEAD_N-1:0] head,
    output logic [CNT_W-1:0]       cnt
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int IN_W  = $clog2(NSLOT);

    slot_ent_t [DEPTH-1:0] mem, mem_nxt;
    logic [CNT_W-1:0]      cnt_q, cnt_nxt;

    always_comb begin
        int keep;
        keep = int'(cnt_q) - int'(pop_n);
        for (int i = 0; i < DEPTH; i++) begin
            int src;
            src        = i + int'(pop_n);
            mem_nxt[i] = '0;
            if (src < int'(cnt_q)) begin
                mem_nxt[i] = mem[IDX_W'(src)];
            end else if (push && i >= keep && i < keep + NSLOT) begin
                mem_nxt[i] = ents_in[IN_W'(i - keep)];
            end
        end
        cnt_nxt = CNT_W'(keep + (push ? NSLOT : 0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem   <= '0;
            cnt_q <= '0;
        end else begin
            mem   <= mem_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    for (genvar h = 0; h < HEAD_N; h++) begin : g_head
        assign head[h] = mem[h];
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/vliw_grp_scan.sv
module vliw_grp_scan #(
    parameter int ISSUE_W = 6,
    parameter int CNT_W   = 4
) (
    input  logic [ISSUE_W-1:0] stop_head,
    input  logic [CNT_W-1:0]   cnt,
    output logic [CNT_W-1:0]   emit_n,
    output logic               eog
);

    always_comb begin
        logic found;
        int   n;
        found = 1'b0;
        n     = 0;
        for (int i = 0; i < ISSUE_W; i++) begin
            if (!found && i < int'(cnt) && stop_head[i]) begin
                found = 1'b1;
                n     = i + 1;
            end
        end
        if (found) begin
            emit_n = CNT_W'(n);
            eog    = 1'b1;
        end else if (int'(cnt) >= ISSUE_W) begin
            emit_n = CNT_W'(ISSUE_W);
            eog    = 1'b0;
        end else begin
            emit_n = '0;
            eog    = 1'b0;
        end
    end

endmodule

// File: rtl/vliw_group_splitter.sv
module vliw_group_splitter
    import vliw_grp_pkg::*;
#(
    parameter int ISSUE_W = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [BUNDLE_W-1:0]       in_bundle,
    output logic                      in_ready,
    output logic [ISSUE_W-1:0]        out_valid,
    output logic [ISSUE_W*SLOT_W-1:0] out_op,
    output logic [ISSUE_W*TMPL_W-1:0] out_tmpl,
    output logic                      out_eog
);

    localparam int DEPTH      = ISSUE_W + NSLOT - 1;
    localparam int CNT_W      = $clog2(DEPTH + 1);
    localparam int ACCEPT_MAX = DEPTH - NSLOT;

    slot_ent_t [NSLOT-1:0]   ents;
    slot_ent_t [ISSUE_W-1:0] head;
    logic [ISSUE_W-1:0]      stop_head;
    logic [CNT_W-1:0]        cnt;
    logic [CNT_W-1:0]        emit_n;
    logic                    grp_end;
    logic                    push;

    vliw_grp_unpack u_unpack (
        .bundle (in_bundle),
        .ents   (ents)
    );

    vliw_grp_queue #(
        .DEPTH  (DEPTH),
        .HEAD_N (ISSUE_W),
        .CNT_W  (CNT_W)
    ) u_queue (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .ents_in (ents),
        .pop_n   (emit_n),
        .head    (head),
        .cnt     (cnt)
    );

    vliw_grp_scan #(
        .ISSUE_W (ISSUE_W),
        .CNT_W   (CNT_W)
    ) u_scan (
        .stop_head (stop_head),
        .cnt       (cnt),
        .emit_n    (emit_n),
        .eog       (grp_end)
    );

    assign in_ready = (int'(cnt) - int'(emit_n)) <= ACCEPT_MAX;
    assign push     = in_valid && in_ready;
    assign out_eog  = grp_end;

    for (genvar l = 0; l < ISSUE_W; l++) begin : g_lane
        assign stop_head[l]                   = head[l].stop;
        assign out_valid[l]                   = (l < int'(emit_n));
        assign out_op[l*SLOT_W +: SLOT_W]     = out_valid[l] ? head[l].op   : '0;
        assign out_tmpl[l*TMPL_W +: TMPL_W]   = out_valid[l] ? head[l].tmpl : '0;
    end

endmodule

// File: rtl/vliw_grp_chk.sv
module vliw_grp_chk
    import vliw_grp_pkg::*;
#(
    parameter int ISSUE_W = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic [ISSUE_W-1:0] out_valid,
    input logic               out_eog
);

    localparam int DEPTH = ISSUE_W + NSLOT - 1;
    localparam int OCC_W = $clog2(DEPTH + 1) + 1;

    logic [OCC_W-1:0] occ;
    int               pc;

    always_comb begin
        pc = 0;
        for (int i = 0; i < ISSUE_W; i++) pc += int'(out_valid[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= OCC_W'(int'(occ) + ((in_valid && in_ready) ? NSLOT : 0) - pc);
    end

    // R7: occupancy seen from the ports never exceeds the queue depth
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        int'(occ) <= DEPTH) else $error("occupancy overflow");

    // R7: no lane is presented that was never taken in
    assert_emit_stored_R7: assert property (@(posedge clk) disable iff (rst)
        pc <= int'(occ)) else $error("lane presented without stored slot");

    // R7: a stall always coincides with forward progress
    assert_stall_progress_R7: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> |out_valid) else $error("stall without emission");

    // R6: lane valid bits are contiguous from lane 0
    assert_contig_valid_R6: assert property (@(posedge clk) disable iff (rst)
        ((out_valid + ISSUE_W'(1)) & out_valid) == '0) else $error("gap in valid lanes");

    // R6: end-of-group only with at least one lane
    assert_eog_needs_op_R6: assert property (@(posedge clk) disable iff (rst)
        out_eog |-> |out_valid) else $error("end-of-group with no lanes");

    // R5: a group is cut short only at full issue width
    assert_split_full_R5: assert property (@(posedge clk) disable iff (rst)
        (|out_valid && !out_eog) |-> &out_valid) else $error("partial split");

    // R9: reset leaves the block empty and accepting
    assert_reset_empty_R9: assert property (@(posedge clk)
        rst |=> (out_valid == '0 && in_ready && !out_eog)) else $error("not empty after reset");

endmodule

bind vliw_group_splitter vliw_grp_chk #(.ISSUE_W(ISSUE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_eog   (out_eog)
);

// File: tb/vliw_group_splitter_tb.sv
module vliw_group_splitter_tb;
    import vliw_grp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ISSUE_W    = 6;
    localparam int MAXB       = 32;
    localparam int N_TBL      = 14;
    localparam int N_EXP      = 11;
    // stimulus templates, walked in order as one stream
    localparam logic [4:0] TBL [N_TBL] = '{
        5'b00101, 5'b01010, 5'b10001, 5'b00000, 5'b11100, 5'b00011, 5'b00000,
        5'b00000, 5'b01000, 5'b00010, 5'b00000, 5'b10101, 5'b00000, 5'b00001};
    // expected presentations: lane count and end-of-group
    localparam int EXP_N   [N_EXP] = '{3, 2, 4, 6, 2, 1, 6, 5, 6, 1, 6};
    localparam int EXP_EOG [N_EXP] = '{1, 1, 1, 0, 1, 1, 0, 1, 0, 1, 1};

    logic                      clk = 1'b0;
    logic                      rst;
    logic                      in_valid;
    logic [BUNDLE_W-1:0]       in_bundle;
    logic                      in_ready;
    logic [ISSUE_W-1:0]        out_valid;
    logic [ISSUE_W*SLOT_W-1:0] out_op;
    logic [ISSUE_W*TMPL_W-1:0] out_tmpl;
    logic                      out_eog;

    logic [4:0] tm [MAXB];
    int nb, exp_s, emit_idx, checks, fails, stalls;
    bit tbl_mode;

    vliw_group_splitter #(.ISSUE_W(ISSUE_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bundle (in_bundle),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_op    (out_op),
        .out_tmpl  (out_tmpl),
        .out_eog   (out_eog)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [SLOT_W-1:0] mk_op(input int s);
        return {1'b1, 8'hA5, 32'(s)};
    endfunction

    function automatic logic [BUNDLE_W-1:0] mk_bundle(input int b);
        return {mk_op(3*b+2), mk_op(3*b+1), mk_op(3*b), tm[b]};
    endfunction

    // stop after serial s, from R2/R3 bit meanings
    function automatic bit stop_at(input int s);
        int b, p;
        b = s / 3;
        p = s % 3;
        if (b >= nb) return 1'b0;
        if (p == 1) return tm[b][1];
        if (p == 2) return tm[b][0];
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // presentation monitor
    always @(negedge clk) begin
        if (rst) begin
            exp_s    = 0;
            emit_idx = 0;
        end else if (|out_valid) begin : mon
            int n, lastp, badl, got;
            bit eg, span, okd, okt;
            string tag;
            n = 0; eg = 1'b0;
            for (int k = 0; k < ISSUE_W; k++) begin
                n++;
                if (stop_at(exp_s + k)) begin eg = 1'b1; break; end
            end
            span  = (exp_s / 3) != ((exp_s + n - 1) / 3);
            lastp = (exp_s + n - 1) % 3;
            tag   = !eg ? "R5" : span ? "R4" : (lastp == 1) ? "R3" : "R2";
            check(out_valid == ISSUE_W'((1 << n) - 1), tag, "lane valid bits",
                  128'(out_valid), 128'((1 << n) - 1));
            check(out_eog == eg, tag, "end-of-group", 128'(out_eog), 128'(eg));
            got = $countones(out_valid);
            okd = 1'b1; okt = 1'b1; badl = 0;
            for (int l = 0; l < got; l++) begin
                if (out_op[l*SLOT_W +: SLOT_W] != mk_op(exp_s + l) && okd) begin
                    okd = 1'b0; badl = l;
                end
                if (out_tmpl[l*TMPL_W +: TMPL_W] != tm[(exp_s + l) / 3]) okt = 1'b0;
            end
            check(okd, "R1", "lane operation order",
                  128'(out_op[badl*SLOT_W +: SLOT_W]), 128'(mk_op(exp_s + badl)));
            check(okt, "R8", "lane template", 128'(out_tmpl), 128'(tm[exp_s / 3]));
            if (tbl_mode && emit_idx < N_EXP) begin
                check(got == EXP_N[emit_idx] && int'(out_eog) == EXP_EOG[emit_idx],
                      (EXP_EOG[emit_idx] == 0) ? "R5" : "R4", "table vector",
                      128'(got), 128'(EXP_N[emit_idx]));
            end
            emit_idx++;
            exp_s += got;
        end
    end

    task automatic pulse_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic feed();
        for (int b = 0; b < nb; b++) begin
            bit r;
            in_valid  = 1'b1;
            in_bundle = mk_bundle(b);
            r = 1'b0;
            while (!r) begin
                @(negedge clk);
                r = in_ready;
                if (!r) stalls++;
                @(posedge clk);
                #1;
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int c = 0; c < 100 && exp_s < 3*nb; c++) @(posedge clk);
        #1;
        check(exp_s == 3*nb, "R7", "whole stream presented", 128'(exp_s), 128'(3*nb));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        checks = 0; fails = 0; stalls = 0; nb = 0; tbl_mode = 1'b0;
        exp_s = 0; emit_idx = 0;
        in_valid = 1'b0; in_bundle = '0; rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R9 reset state
        @(negedge clk);
        check(out_valid == '0 && !out_eog, "R9", "idle outputs after reset",
              128'(out_valid), 128'(0));
        check(in_ready == 1'b1, "R9", "ready after reset", 128'(in_ready), 128'(1));

        // R11 latency and R10 one group per cycle
        @(posedge clk); #1;
        nb = 1; tm[0] = 5'b00011;
        in_valid = 1'b1; in_bundle = mk_bundle(0);
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 6'b000011 && out_eog, "R11", "group right after accept",
              128'(out_valid), 128'(6'b000011));
        @(negedge clk);
        check(out_valid == 6'b000001 && out_eog, "R10", "younger group next cycle",
              128'(out_valid), 128'(6'b000001));
        @(negedge clk);
        check(out_valid == '0, "R10", "nothing left", 128'(out_valid), 128'(0));
        @(posedge clk); #1;

        // R9 reset drops buffered, unfinished slots
        pulse_reset();
        nb = 1; tm[0] = 5'b00000;
        feed();
        pulse_reset();
        @(negedge clk);
        check(out_valid == '0 && in_ready, "R9", "queue cleared by reset",
              128'(out_valid), 128'(0));
        @(posedge clk); #1;
        nb = 1; tm[0] = 5'b00001;
        feed();
        @(negedge clk);
        check(out_valid == 6'b000111, "R9", "only fresh slots after reset",
              128'(out_valid), 128'(6'b000111));
        @(posedge clk); #1;
        drain();

        // table-driven stream
        pulse_reset();
        for (int b = 0; b < N_TBL; b++) tm[b] = TBL[b];
        nb = N_TBL; tbl_mode = 1'b1;
        feed();
        drain();
        check(emit_idx == N_EXP, "R4", "presentation count of table stream",
              128'(emit_idx), 128'(N_EXP));
        tbl_mode = 1'b0;

        // R7 back-pressure under back-to-back small groups
        pulse_reset();
        for (int b = 0; b < 8; b++) tm[b] = 5'b00011;
        nb = 8; stalls = 0;
        feed();
        drain();
        check(stalls > 0, "R7", "input stalled while queue full", 128'(stalls), 128'(1));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule